// File: doc/BRIEF.md
# ATM Cell Transmit Buffer with Loopback Routing

This block sits on the transmit side of a cell-oriented physical layer. An upstream device hands it 53-byte cells one byte per clock over a valid/ready stream. A start-of-cell flag marks byte 0. The block assembles the bytes into a two-slot cell buffer. When a cell's last byte is taken, the block routes the cell either to the line output stream or back toward the upstream receive side (PHY loopback). The choice follows a 2-bit routing mode sampled at that moment.

A software hold bit stops the upstream flow. In byte-level handshake mode the hold closes `up_ready` at once, so a cell can be left half built. The block keeps that cell until the hold is released, then finishes it. A new start-of-cell that arrives while a half-built cell is held throws the old bytes away. In cell-level handshake mode, a cell that has started is always taken in full, and the hold only blocks new cells. `cell_avail` tells the upstream device that a whole cell slot is free and the hold is clear.

Back-pressure rules: an upstream byte moves on a cycle where `up_valid` and `up_ready` are both high. On each output stream a byte moves when that stream's valid and ready are both high. While valid is high and ready is low, the byte and its start flag stay unchanged.

Top module: `cell_tx_buffer`

## Requirements
- R1: A cell is 53 bytes. A cell whose 53rd byte is accepted is later emitted, in order of completion and in byte order, as 53 bytes on one output stream. The start flag of that stream is high on the first byte only.
- R2: `cell_avail` is high exactly when `sw_hold` is low and the number of complete stored cells plus any cell in progress is below two.
- R3: With `cell_hs` = 0, `sw_hold` high forces `up_ready` low, even partway through a cell. A partly built cell is never emitted.
- R4: After `sw_hold` returns low, the held partial cell continues from the byte where it stopped and is emitted once it is complete.
- R5: A start-of-cell byte accepted while a cell is in progress discards the bytes gathered so far and becomes byte 0 of a new cell.
- R6: With `cell_hs` = 1, `up_ready` stays high for the rest of a cell in progress whatever `sw_hold` is. When no cell is in progress, `up_ready` is high only if `sw_hold` is low and a slot is free.
- R7: The output stream is chosen from `route_mode` at the cycle the 53rd byte is accepted. 2'b01 (PHY loopback) selects the loop stream. 2'b00 (normal), 2'b10 (line loopback) and 2'b11 (reserved) select the line stream.
- R8: On each output stream, valid, data and start flag hold steady while valid is high and ready is low. No byte is lost or repeated.
- R9: `tx_count` resets to 0. It rises by one for each cell whose last byte leaves on either stream, and it wraps to 0 after its all-ones value.
- R10: Bytes without start-of-cell that arrive while no cell is in progress are accepted when `up_ready` is high and then dropped.
- R11: During and after reset no output stream is valid, `tx_count` is 0 and, with the hold clear, `cell_avail` and `up_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_valid | input | 1 | Upstream byte valid |
| up_ready | output | 1 | Block takes the upstream byte |
| up_data | input | DATA_W | Upstream cell byte |
| up_soc | input | 1 | Upstream byte is byte 0 of a cell |
| cell_avail | output | 1 | A whole cell slot is free and the hold is clear |
| sw_hold | input | 1 | Software flow-control hold bit |
| cell_hs | input | 1 | 1: cell-level handshake, 0: byte-level handshake |
| route_mode | input | 2 | 00 normal, 01 PHY loopback, 10 line loopback, 11 reserved (as normal) |
| line_valid | output | 1 | Line stream byte valid |
| line_ready | input | 1 | Line side takes the byte |
| line_data | output | DATA_W | Line stream byte |
| line_soc | output | 1 | Line byte is byte 0 of a cell |
| loop_valid | output | 1 | Loop stream byte valid |
| loop_ready | input | 1 | Loop side takes the byte |
| loop_data | output | DATA_W | Loop stream byte |
| loop_soc | output | 1 | Loop byte is byte 0 of a cell |
| tx_count | output | CNT_W | Count of cells sent, wraps |

## Verification
Whole cells are sent with every routing code. These runs separate the line and loop destinations, including a code change made partway through a cell. Hold pulses in byte mode show a kept-and-resumed cell apart from a cell discarded by a fresh start flag. The same pulse in cell mode must leave the cell's tail flowing. Two cells are stored behind a stalled line output, which tests the free-slot limit on `cell_avail`. Random ready patterns on the outputs test that held bytes stay steady. Stray bytes with no start flag test that idle input is dropped. Enough cells are sent with a narrow counter to cover its wrap.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;
  typedef enum logic [1:0] {
    RT_NORMAL    = 2'b00,
    RT_PHY_LOOP  = 2'b01,
    RT_LINE_LOOP = 2'b10,
    RT_RESERVED  = 2'b11
  } route_e;

  localparam int unsigned CELL_LEN = 53;
endpackage

// File: rtl/cell_ingress.sv
module cell_ingress
  import cell_tx_pkg::*;
#(
  parameter int unsigned CELL_BYTES = CELL_LEN,
  parameter int unsigned SLOTS      = 2,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned OCC_W     = $clog2(SLOTS + 1),
  localparam int unsigned POS_W     = $clog2(CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_soc,
  output logic              in_ready,
  output logic              cell_avail,
  input  logic              hold,
  input  logic              cell_hs,
  input  logic [1:0]        mode,
  input  logic [OCC_W-1:0]  stored_cnt,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              busy,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [POS_W-1:0]  wr_pos,
  output logic [DATA_W-1:0] wr_data,
  output logic              cell_done,
  output logic              done_loop
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_BYTES - 1);

  logic              active;
  logic [SLOT_W-1:0] cur_slot;
  logic [POS_W-1:0]  pos;
  logic [SLOT_W-1:0] start_slot;
  logic              slot_free;
  logic              accept;

  always_comb begin
    int s;
    s = int'(rd_slot) + int'(stored_cnt);
    if (s >= int'(SLOTS)) s = s - int'(SLOTS);
    start_slot = SLOT_W'(s);
  end

  assign slot_free  = int'(stored_cnt) < int'(SLOTS);
  assign cell_avail = !hold && (int'(stored_cnt) + int'(active) < int'(SLOTS));
  assign in_ready   = active ? (cell_hs || !hold) : (!hold && slot_free);
  assign accept     = in_valid && in_ready;

  assign busy      = active;
  assign wr_en     = accept && (in_soc || active);
  assign wr_slot   = (in_soc && !active) ? start_slot : cur_slot;
  assign wr_pos    = in_soc ? '0 : pos;
  assign wr_data   = in_data;
  assign cell_done = accept && active && !in_soc && (pos == LAST_POS);
  assign done_loop = (mode == RT_PHY_LOOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cur_slot <= '0;
      pos      <= '0;
    end else if (accept) begin
      if (in_soc) begin
        active   <= 1'b1;
        cur_slot <= wr_slot;
        pos      <= POS_W'(1);
      end else if (active) begin
        if (pos == LAST_POS) begin
          active <= 1'b0;
          pos    <= '0;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cell_store.sv
module cell_store #(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned SLOTS      = 2,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned POS_W     = $clog2(CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [POS_W-1:0]  wr_pos,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cell_done,
  input  logic              done_loop,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [POS_W-1:0]  rd_pos,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_loop
);
  logic [DATA_W-1:0] mem [SLOTS][CELL_BYTES];
  logic [SLOTS-1:0]  loop_flag;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot][wr_pos] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         loop_flag <= '0;
    else if (cell_done) loop_flag[wr_slot] <= done_loop;
  end

  assign rd_data = mem[rd_slot][rd_pos];
  assign rd_loop = loop_flag[rd_slot];
endmodule

// File: rtl/cell_egress.sv
module cell_egress #(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned SLOTS      = 2,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned OCC_W     = $clog2(SLOTS + 1),
  localparam int unsigned POS_W     = $clog2(CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_done,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_loop,
  output logic [OCC_W-1:0]  stored_cnt,
  output logic [SLOT_W-1:0] rd_slot,
  output logic [POS_W-1:0]  rd_pos,
  output logic              line_valid,
  input  logic              line_ready,
  output logic [DATA_W-1:0] line_data,
  output logic              line_soc,
  output logic              loop_valid,
  input  logic              loop_ready,
  output logic [DATA_W-1:0] loop_data,
  output logic              loop_soc,
  output logic [CNT_W-1:0]  tx_count
);
  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic have, take, fin;

  assign have       = (stored_cnt != '0);
  assign line_valid = have && !rd_loop;
  assign loop_valid = have && rd_loop;
  assign line_data  = rd_data;
  assign loop_data  = rd_data;
  assign line_soc   = (rd_pos == '0);
  assign loop_soc   = (rd_pos == '0);
  assign take       = (line_valid && line_ready) || (loop_valid && loop_ready);
  assign fin        = take && (rd_pos == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_cnt <= '0;
      rd_slot    <= '0;
      rd_pos     <= '0;
      tx_count   <= '0;
    end else begin
      if (cell_done && !fin)      stored_cnt <= stored_cnt + 1'b1;
      else if (!cell_done && fin) stored_cnt <= stored_cnt - 1'b1;
      if (take) begin
        if (fin) begin
          rd_pos   <= '0;
          rd_slot  <= (rd_slot == LAST_SLOT) ? '0 : rd_slot + 1'b1;
          tx_count <= tx_count + 1'b1;
        end else begin
          rd_pos <= rd_pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cell_tx_buffer.sv
module cell_tx_buffer
  import cell_tx_pkg::*;
#(
  parameter int unsigned CELL_BYTES = CELL_LEN,
  parameter int unsigned SLOTS      = 2,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_soc,
  output logic              cell_avail,
  input  logic              sw_hold,
  input  logic              cell_hs,
  input  logic [1:0]        route_mode,
  output logic              line_valid,
  input  logic              line_ready,
  output logic [DATA_W-1:0] line_data,
  output logic              line_soc,
  output logic              loop_valid,
  input  logic              loop_ready,
  output logic [DATA_W-1:0] loop_data,
  output logic              loop_soc,
  output logic [CNT_W-1:0]  tx_count
);
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned OCC_W  = $clog2(SLOTS + 1);
  localparam int unsigned POS_W  = $clog2(CELL_BYTES);

  logic              busy, wr_en, cell_done, done_loop, rd_loop;
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [POS_W-1:0]  wr_pos, rd_pos;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [OCC_W-1:0]  stored_cnt;

  cell_ingress #(.CELL_BYTES(CELL_BYTES), .SLOTS(SLOTS), .DATA_W(DATA_W)) i_ingress (
    .clk(clk), .rst_n(rst_n),
    .in_valid(up_valid), .in_data(up_data), .in_soc(up_soc), .in_ready(up_ready),
    .cell_avail(cell_avail), .hold(sw_hold), .cell_hs(cell_hs), .mode(route_mode),
    .stored_cnt(stored_cnt), .rd_slot(rd_slot), .busy(busy),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_pos(wr_pos), .wr_data(wr_data),
    .cell_done(cell_done), .done_loop(done_loop)
  );

  cell_store #(.CELL_BYTES(CELL_BYTES), .SLOTS(SLOTS), .DATA_W(DATA_W)) i_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_pos(wr_pos), .wr_data(wr_data),
    .cell_done(cell_done), .done_loop(done_loop),
    .rd_slot(rd_slot), .rd_pos(rd_pos), .rd_data(rd_data), .rd_loop(rd_loop)
  );

  cell_egress #(.CELL_BYTES(CELL_BYTES), .SLOTS(SLOTS), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_egress (
    .clk(clk), .rst_n(rst_n), .cell_done(cell_done),
    .rd_data(rd_data), .rd_loop(rd_loop),
    .stored_cnt(stored_cnt), .rd_slot(rd_slot), .rd_pos(rd_pos),
    .line_valid(line_valid), .line_ready(line_ready), .line_data(line_data), .line_soc(line_soc),
    .loop_valid(loop_valid), .loop_ready(loop_ready), .loop_data(loop_data), .loop_soc(loop_soc),
    .tx_count(tx_count)
  );
endmodule

// File: rtl/cell_tx_buffer_chk.sv
module cell_tx_buffer_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_ready,
  input logic              cell_avail,
  input logic              sw_hold,
  input logic              cell_hs,
  input logic              busy,
  input logic              line_valid,
  input logic              line_ready,
  input logic [DATA_W-1:0] line_data,
  input logic              line_soc,
  input logic              loop_valid,
  input logic              loop_ready,
  input logic [DATA_W-1:0] loop_data,
  input logic              loop_soc,
  input logic [CNT_W-1:0]  tx_count
);
  // R8
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid && !line_ready |=> line_valid && $stable(line_data) && $stable(line_soc));

  // R8
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_valid && !loop_ready |=> loop_valid && $stable(loop_data) && $stable(loop_soc));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count != $past(tx_count) |-> tx_count == CNT_W'($past(tx_count) + 1'b1));

  // R2
  avail_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_avail |-> up_ready);

  // R6
  cell_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_hs && busy |-> up_ready);

  // R3
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_hs && sw_hold |-> !up_ready);
endmodule

bind cell_tx_buffer cell_tx_buffer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_ready(up_ready), .cell_avail(cell_avail),
  .sw_hold(sw_hold), .cell_hs(cell_hs), .busy(busy),
  .line_valid(line_valid), .line_ready(line_ready), .line_data(line_data), .line_soc(line_soc),
  .loop_valid(loop_valid), .loop_ready(loop_ready), .loop_data(loop_data), .loop_soc(loop_soc),
  .tx_count(tx_count)
);

// File: tb/test_cell_tx_buffer.sv
module test_cell_tx_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int CB = 53;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_valid = 1'b0, up_soc = 1'b0, sw_hold = 1'b0, cell_hs = 1'b0;
  logic [7:0] up_data = '0;
  logic [1:0] route_mode = 2'b00;
  logic line_ready = 1'b1, loop_ready = 1'b1;
  logic up_ready, cell_avail, line_valid, line_soc, loop_valid, loop_soc;
  logic [7:0] line_data, loop_data;
  logic [CW-1:0] tx_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_tx_buffer #(.CNT_W(CW)) i_cell_tx_buffer (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_data(up_data), .up_soc(up_soc), .cell_avail(cell_avail),
    .sw_hold(sw_hold), .cell_hs(cell_hs), .route_mode(route_mode),
    .line_valid(line_valid), .line_ready(line_ready), .line_data(line_data), .line_soc(line_soc),
    .loop_valid(loop_valid), .loop_ready(loop_ready), .loop_data(loop_data), .loop_soc(loop_soc),
    .tx_count(tx_count)
  );

  int checks = 0;
  int errors = 0;
  bit last_acc;
  bit bp_rand = 1'b0;

  // reference model state
  logic [7:0] m_part[$];
  logic [7:0] m_cells[$];
  bit         m_dest[$];
  bit         m_active = 1'b0;
  int         m_rdpos = 0;
  int         m_cnt = 0;

  function automatic logic [7:0] cbyte(int id, int i);
    return 8'((id * 37 + i * 3) & 255);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // called at a falling edge with inputs already set
  task automatic step(string tag);
    bit e_ready, e_avail, e_lv, e_pv, fire, acc;
    int nc;
    if (bp_rand) begin
      line_ready = 1'($urandom_range(0, 1));
      loop_ready = 1'($urandom_range(0, 1));
    end
    #1;
    nc = m_dest.size();
    e_ready = m_active ? (cell_hs || !sw_hold) : (!sw_hold && nc < 2);
    e_avail = !sw_hold && (nc + int'(m_active) < 2);
    e_lv = (nc > 0) && !m_dest[0];
    e_pv = (nc > 0) && m_dest[0];
    chk(tag, "up_ready", 32'(up_ready), 32'(e_ready));
    chk(tag, "cell_avail", 32'(cell_avail), 32'(e_avail));
    chk(tag, "line_valid", 32'(line_valid), 32'(e_lv));
    chk(tag, "loop_valid", 32'(loop_valid), 32'(e_pv));
    if (e_lv) begin
      chk(tag, "line_data", 32'(line_data), 32'(m_cells[m_rdpos]));
      chk(tag, "line_soc", 32'(line_soc), 32'(m_rdpos == 0));
    end
    if (e_pv) begin
      chk(tag, "loop_data", 32'(loop_data), 32'(m_cells[m_rdpos]));
      chk(tag, "loop_soc", 32'(loop_soc), 32'(m_rdpos == 0));
    end
    chk(tag, "tx_count", 32'(tx_count), 32'(m_cnt));
    fire = (nc > 0) && (m_dest[0] ? loop_ready : line_ready);
    acc  = up_valid && e_ready;
    last_acc = acc;
    if (fire) begin
      m_rdpos++;
      if (m_rdpos == CB) begin
        repeat (CB) void'(m_cells.pop_front());
        void'(m_dest.pop_front());
        m_rdpos = 0;
        m_cnt = (m_cnt + 1) % (1 << CW);
      end
    end
    if (acc) begin
      if (up_soc) begin
        m_part.delete();
        m_part.push_back(up_data);
        m_active = 1'b1;
      end else if (m_active) begin
        m_part.push_back(up_data);
        if (m_part.size() == CB) begin
          foreach (m_part[k]) m_cells.push_back(m_part[k]);
          m_dest.push_back(route_mode == 2'b01);
          m_part.delete();
          m_active = 1'b0;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(int n, string tag);
    up_valid = 1'b0;
    up_soc = 1'b0;
    repeat (n) step(tag);
  endtask

  task automatic send_bytes(int id, int first, int last, string tag);
    int i;
    i = first;
    while (i <= last) begin
      up_valid = 1'b1;
      up_data = cbyte(id, i);
      up_soc = (i == 0);
      step(tag);
      if (last_acc) i++;
    end
    up_valid = 1'b0;
    up_soc = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: values while reset is held
    chk("R11", "tx_count in reset", 32'(tx_count), 32'd0);
    chk("R11", "line_valid in reset", 32'(line_valid), 32'd0);
    chk("R11", "loop_valid in reset", 32'(loop_valid), 32'd0);
    chk("R11", "cell_avail in reset", 32'(cell_avail), 32'd1);
    rst_n = 1'b1;
    idle(3, "R11");

    // R1 / R7: one cell per routing code
    route_mode = 2'b00; send_bytes(1, 0, CB-1, "R1"); idle(60, "R1");
    route_mode = 2'b01; send_bytes(2, 0, CB-1, "R7"); idle(60, "R7");
    route_mode = 2'b10; send_bytes(3, 0, CB-1, "R7"); idle(60, "R7");
    route_mode = 2'b11; send_bytes(4, 0, CB-1, "R7"); idle(60, "R7");

    // R7: mode changed before the last byte
    route_mode = 2'b00; send_bytes(5, 0, 40, "R7");
    route_mode = 2'b01; send_bytes(5, 41, CB-1, "R7");
    idle(60, "R7");
    route_mode = 2'b00;

    // R3 then R4: byte mode hold mid-cell, then resume
    send_bytes(6, 0, 19, "R3");
    sw_hold = 1'b1;
    up_valid = 1'b1; up_data = cbyte(6, 20); up_soc = 1'b0;
    repeat (8) step("R3");
    up_valid = 1'b0;
    idle(5, "R3");
    sw_hold = 1'b0;
    send_bytes(6, 20, CB-1, "R4");
    idle(60, "R4");

    // R5: partial cell discarded by a new start
    send_bytes(7, 0, 29, "R5");
    sw_hold = 1'b1; idle(3, "R5"); sw_hold = 1'b0;
    send_bytes(8, 0, CB-1, "R5");
    idle(60, "R5");

    // R6: cell mode keeps the tail flowing, blocks the next start
    cell_hs = 1'b1;
    send_bytes(9, 0, 9, "R6");
    sw_hold = 1'b1;
    send_bytes(9, 10, CB-1, "R6");
    up_valid = 1'b1; up_data = cbyte(10, 0); up_soc = 1'b1;
    repeat (4) step("R6");
    up_valid = 1'b0; up_soc = 1'b0;
    sw_hold = 1'b0;
    send_bytes(10, 0, CB-1, "R6");
    idle(120, "R6");
    cell_hs = 1'b0;

    // R2: two cells stored behind a stalled line output
    line_ready = 1'b0;
    send_bytes(11, 0, CB-1, "R2");
    send_bytes(12, 0, CB-1, "R2");
    up_valid = 1'b1; up_data = cbyte(13, 0); up_soc = 1'b1;
    repeat (4) step("R2");
    up_valid = 1'b0; up_soc = 1'b0;
    line_ready = 1'b1;
    idle(120, "R2");

    // R10: stray bytes with no start flag while idle
    up_valid = 1'b1; up_soc = 1'b0;
    for (int k = 0; k < 6; k++) begin
      up_data = 8'(200 + k);
      step("R10");
    end
    up_valid = 1'b0;
    idle(4, "R10");
    send_bytes(14, 0, CB-1, "R10");
    idle(60, "R10");

    // R8: random ready on both streams, both destinations
    bp_rand = 1'b1;
    route_mode = 2'b00; send_bytes(15, 0, CB-1, "R8");
    route_mode = 2'b01; send_bytes(16, 0, CB-1, "R8");
    route_mode = 2'b00; send_bytes(17, 0, CB-1, "R8");
    idle(400, "R8");
    bp_rand = 1'b0;
    line_ready = 1'b1; loop_ready = 1'b1;

    // R9: counter has wrapped by now (narrow width); one more cell
    send_bytes(18, 0, CB-1, "R9");
    idle(60, "R9");
    chk("R9", "tx_count after wrap", 32'(tx_count), 32'(m_cnt));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule